// File: doc/BRIEF.md
# Page Buffer Column Mapper

This block provides byte-wide access to a flash controller's page buffer through a single running column pointer. The column space is linear: first the main bytes of a page, then its spare bytes. Inside the buffer, the main bytes sit in one contiguous region that starts at offset 0. The spare bytes are split across eight fixed 64-byte windows, and the first window starts at offset 0x1000. The buffer storage is part of the block.

The caller sets the page geometry at run time:
- `pg_sel` selects a page of 512 << `pg_sel` bytes. The spare bytes are then spread over 1 << `pg_sel` windows.
- `spare_size` gives the number of spare bytes.

A set-column strobe loads the pointer and an optional spare-only mode. Each later access reads or writes one byte and moves the pointer forward. A burst may therefore run from the main area straight into the spare area. The mapped buffer offset of the current pointer is visible on `buf_addr`.

Top module: `nfcbuf_mapper`

## Requirements
- R1: After reset, `col_ptr` is 0, `rvalid` is 0 and spare-only mode is off.
- R2: A cycle with `set_col` high loads `col_in` into the pointer and `spare_only_in` into the mode. Any access requested in that same cycle is dropped: no write takes place and `rvalid` stays low.
- R3: Each cycle with `req` high and `set_col` low moves the pointer forward by exactly one, for both reads and writes. With neither `req` nor `set_col` high, the pointer holds its value.
- R4: Outside spare-only mode, a pointer below the page size (512 << `pg_sel`) maps to buffer offset equal to the pointer.
- R5: The per-window share is `spare_size >> pg_sel` with bit 0 cleared. For a spare offset s, the window index is s divided by the share, and `buf_addr` = 0x1000 + 64×index + (s − index×share).
- R6: Outside spare-only mode, a pointer at or above the page size gives spare offset (pointer − page size). A burst that crosses the last main byte continues at spare offset 0, with no skipped or repeated cycle.
- R7: In spare-only mode, the pointer value itself is the spare offset.
- R8: The window index is capped at the last used window, (1 << `pg_sel`) − 1. The bytes left over by the even rounding therefore land in that window, beyond its normal share.
- R9: A read request (`req`=1, `we`=0, `set_col`=0) produces `rdata` together with a one-cycle `rvalid` pulse on the next cycle.
- R10: A spare offset at or beyond `spare_size`, or a window offset of 64 or more, is out of range. In that case `buf_addr` shows all ones (0x1FFF), a read returns 0xFF, and a write changes no stored byte.
- R11: A byte written to a mapped location is returned by a later read of the same column under the same geometry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pg_sel | input | 2 | Page size select: 512 << pg_sel bytes (up to MAX_PG_SEL) |
| spare_size | input | 8 | Spare bytes per page |
| set_col | input | 1 | Load pointer and mode strobe |
| col_in | input | 12 | Column value to load |
| spare_only_in | input | 1 | Spare-only mode loaded with set_col |
| req | input | 1 | Byte access request |
| we | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after request |
| col_ptr | output | 12 | Current column pointer |
| buf_addr | output | 13 | Buffer offset of the current pointer, 0x1FFF if out of range |

## Verification
The bench first fills a whole 512-byte page and its spare area through one write burst, then reads it back. This shows whether the main-to-spare crossing shifts or drops a byte. Several geometries are then tried:
- An even division of the spare bytes (64 bytes over four windows) checks the basic window arithmetic.
- An uneven division (70 bytes over four windows) separates folding into the last window from spilling into an unused window.
- A share larger than a window exposes offsets past 64 bytes.

Spare-only loads, columns past the end of the spare area, and a set-column strobe that coincides with a write show whether the mode, the out-of-range guard and the strobe priority hold.

// File: rtl/nfcbuf_pkg.sv
package nfcbuf_pkg;
    localparam int BYTES_PER_CHUNK = 512;
    localparam int SPARE_WINDOWS   = 8;
    localparam int WINDOW_BYTES    = 64;
    localparam int WIN_IDX_W       = $clog2(SPARE_WINDOWS);
    localparam int WIN_OFF_W       = $clog2(WINDOW_BYTES);
    localparam int SPARE_DEPTH     = SPARE_WINDOWS * WINDOW_BYTES;
    localparam int SPARE_AW        = WIN_IDX_W + WIN_OFF_W;
    localparam int BUF_AW          = 13;
    localparam logic [BUF_AW-1:0] ADDR_NONE = '1;

    typedef logic [7:0] byte_t;
endpackage

// File: rtl/nfcbuf_spare_split.sv
module nfcbuf_spare_split #(
    parameter int OFF_W = 12
) (
    input  logic [OFF_W-1:0]                 soff,
    input  logic [1:0]                       pg_sel,
    input  logic [7:0]                       spare_size,
    output logic [nfcbuf_pkg::WIN_IDX_W-1:0] win,
    output logic [OFF_W-1:0]                 woff
);
    import nfcbuf_pkg::*;

    logic [7:0]           share;
    logic [WIN_IDX_W-1:0] last_win;

    always_comb begin
        share    = (spare_size >> pg_sel) & 8'hFE;
        last_win = WIN_IDX_W'((4'd1 << pg_sel) - 4'd1);
        win      = '0;
        for (int k = 1; k < SPARE_WINDOWS; k++) begin
            if ((WIN_IDX_W'(k) <= last_win) &&
                (soff >= OFF_W'(k) * OFF_W'(share))) begin
                win = WIN_IDX_W'(k);
            end
        end
        woff = soff - OFF_W'(win) * OFF_W'(share);
    end
endmodule

// File: rtl/nfcbuf_decode.sv
module nfcbuf_decode #(
    parameter int COL_W   = 12,
    parameter int MAIN_AW = 11
) (
    input  logic [COL_W-1:0]                col,
    input  logic                            spare_only,
    input  logic [1:0]                      pg_sel,
    input  logic [7:0]                      spare_size,
    output logic                            hit_main,
    output logic                            hit_spare,
    output logic [MAIN_AW-1:0]              main_idx,
    output logic [nfcbuf_pkg::SPARE_AW-1:0] spare_idx,
    output logic [nfcbuf_pkg::BUF_AW-1:0]   buf_addr
);
    import nfcbuf_pkg::*;

    logic [COL_W-1:0]     page_bytes;
    logic [COL_W-1:0]     soff;
    logic [WIN_IDX_W-1:0] win;
    logic [COL_W-1:0]     woff;
    logic                 in_main;

    assign page_bytes = COL_W'(BYTES_PER_CHUNK) << pg_sel;
    assign in_main    = !spare_only && (col < page_bytes);
    assign soff       = spare_only ? col : (col - page_bytes);

    nfcbuf_spare_split #(.OFF_W(COL_W)) u_split (
        .soff       (soff),
        .pg_sel     (pg_sel),
        .spare_size (spare_size),
        .win        (win),
        .woff       (woff)
    );

    always_comb begin
        hit_main  = in_main;
        hit_spare = !in_main && (soff < COL_W'(spare_size)) &&
                    (woff < COL_W'(WINDOW_BYTES));
        main_idx  = col[MAIN_AW-1:0];
        spare_idx = {win, woff[WIN_OFF_W-1:0]};
        if (hit_main)
            buf_addr = BUF_AW'(col);
        else if (hit_spare)
            buf_addr = {1'b1, {(BUF_AW-1-SPARE_AW){1'b0}}, spare_idx};
        else
            buf_addr = ADDR_NONE;
    end
endmodule

// File: rtl/nfcbuf_ram.sv
module nfcbuf_ram #(
    parameter int MAIN_DEPTH = 2048,
    parameter int MAIN_AW    = 11
) (
    input  logic                            clk,
    input  logic                            wr_main,
    input  logic                            wr_spare,
    input  logic [MAIN_AW-1:0]              main_idx,
    input  logic [nfcbuf_pkg::SPARE_AW-1:0] spare_idx,
    input  nfcbuf_pkg::byte_t               wdata,
    output nfcbuf_pkg::byte_t               main_rd,
    output nfcbuf_pkg::byte_t               spare_rd
);
    import nfcbuf_pkg::*;

    byte_t main_mem  [MAIN_DEPTH];
    byte_t spare_mem [SPARE_DEPTH];

    always_ff @(posedge clk) begin
        if (wr_main)
            main_mem[main_idx] <= wdata;
        if (wr_spare)
            spare_mem[spare_idx] <= wdata;
    end

    assign main_rd  = main_mem[main_idx];
    assign spare_rd = spare_mem[spare_idx];
endmodule

// File: rtl/nfcbuf_mapper.sv
module nfcbuf_mapper #(
    parameter int MAX_PG_SEL = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  pg_sel,
    input  logic [7:0]  spare_size,
    input  logic        set_col,
    input  logic [11:0] col_in,
    input  logic        spare_only_in,
    input  logic        req,
    input  logic        we,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        rvalid,
    output logic [11:0] col_ptr,
    output logic [12:0] buf_addr
);
    import nfcbuf_pkg::*;

    localparam int MAX_PAGE = BYTES_PER_CHUNK << MAX_PG_SEL;
    localparam int MAIN_AW  = $clog2(MAX_PAGE);
    localparam int COL_W    = 12;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic             spare_only;
        byte_t            rdata;
        logic             rvalid;
    } state_t;

    state_t q, d;

    logic                hit_main, hit_spare;
    logic [MAIN_AW-1:0]  main_idx;
    logic [SPARE_AW-1:0] spare_idx;
    byte_t               main_rd, spare_rd;
    logic                access;

    nfcbuf_decode #(.COL_W(COL_W), .MAIN_AW(MAIN_AW)) u_dec (
        .col        (q.col),
        .spare_only (q.spare_only),
        .pg_sel     (pg_sel),
        .spare_size (spare_size),
        .hit_main   (hit_main),
        .hit_spare  (hit_spare),
        .main_idx   (main_idx),
        .spare_idx  (spare_idx),
        .buf_addr   (buf_addr)
    );

    assign access = req && !set_col;

    nfcbuf_ram #(.MAIN_DEPTH(MAX_PAGE), .MAIN_AW(MAIN_AW)) u_ram (
        .clk       (clk),
        .wr_main   (access && we && hit_main),
        .wr_spare  (access && we && hit_spare),
        .main_idx  (main_idx),
        .spare_idx (spare_idx),
        .wdata     (wdata),
        .main_rd   (main_rd),
        .spare_rd  (spare_rd)
    );

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        if (set_col) begin
            d.col        = col_in;
            d.spare_only = spare_only_in;
        end else if (req) begin
            d.col = q.col + 1'b1;
            if (!we) begin
                d.rvalid = 1'b1;
                if (hit_main)
                    d.rdata = main_rd;
                else if (hit_spare)
                    d.rdata = spare_rd;
                else
                    d.rdata = 8'hFF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign rdata   = q.rdata;
    assign rvalid  = q.rvalid;
    assign col_ptr = q.col;
endmodule

// File: rtl/nfcbuf_mapper_chk.sv
module nfcbuf_mapper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        set_col,
    input logic [11:0] col_in,
    input logic        req,
    input logic        we,
    input logic [7:0]  rdata,
    input logic        rvalid,
    input logic [11:0] col_ptr,
    input logic [12:0] buf_addr
);
    AST_LOAD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        set_col |=> (col_ptr == $past(col_in)));                              // R2

    AST_LOAD_DROPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        set_col |=> !rvalid);                                                 // R2

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !set_col) |=> (col_ptr == $past(col_ptr) + 12'd1));           // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !set_col) |=> $stable(col_ptr));                             // R3

    AST_MAIN_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_addr[12] == 1'b0) |-> (buf_addr == {1'b0, col_ptr}));            // R4

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && !set_col) |=> rvalid);                                 // R9

    AST_OOB_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && !set_col && buf_addr == 13'h1FFF) |=> (rdata == 8'hFF)); // R10
endmodule

bind nfcbuf_mapper nfcbuf_mapper_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_col  (set_col),
    .col_in   (col_in),
    .req      (req),
    .we       (we),
    .rdata    (rdata),
    .rvalid   (rvalid),
    .col_ptr  (col_ptr),
    .buf_addr (buf_addr)
);

// File: tb/tb_nfcbuf_mapper.sv
`timescale 1ns/1ps
module tb_nfcbuf_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pg_sel = '0;
    logic [7:0]  spare_size = '0;
    logic        set_col = 1'b0;
    logic [11:0] col_in = '0;
    logic        spare_only_in = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rvalid;
    logic [11:0] col_ptr;
    logic [12:0] buf_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // behavioural reference state
    int            m_col = 0;
    bit            m_so  = 1'b0;
    logic [7:0]    m_mem [int];

    always #10 clk = ~clk;

    nfcbuf_mapper dut (
        .clk(clk), .rst_n(rst_n), .pg_sel(pg_sel), .spare_size(spare_size),
        .set_col(set_col), .col_in(col_in), .spare_only_in(spare_only_in),
        .req(req), .we(we), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .col_ptr(col_ptr), .buf_addr(buf_addr)
    );

    function automatic int ref_map(int col, bit so, int pgs, int ss);
        int page, chunks, s, share, w, o;
        page   = 512 << pgs;
        chunks = 1 << pgs;
        if (!so && col < page) return col;
        s = so ? col : col - page;
        if (s >= ss) return -1;
        share = (ss / chunks) & ~1;
        w = (share == 0) ? chunks - 1 : s / share;
        if (w > chunks - 1) w = chunks - 1;
        o = s - w * share;
        if (o >= 64) return -1;
        return 4096 + w * 64 + o;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // one clock: inputs driven at negedge, compared against the model
    task automatic tick(string tag, bit sc, int ci, bit so, bit rq, bit w, int wd);
        int a, exp_col, exp_rd;
        bit exp_rv, rd_known;
        set_col = sc; col_in = 12'(ci); spare_only_in = so;
        req = rq; we = w; wdata = 8'(wd);
        #1;
        a = ref_map(m_col, m_so, pg_sel, spare_size);
        check({tag, " addr"}, buf_addr, (a < 0) ? 13'h1FFF : a);
        exp_rv = 1'b0; rd_known = 1'b0; exp_rd = 0;
        exp_col = m_col;
        if (sc) begin
            exp_col = ci; m_so = so;
        end else if (rq) begin
            exp_col = (m_col + 1) % 4096;
            if (w) begin
                if (a >= 0) m_mem[a] = 8'(wd);
            end else begin
                exp_rv = 1'b1;
                if (a < 0) begin exp_rd = 8'hFF; rd_known = 1'b1; end
                else if (m_mem.exists(a)) begin exp_rd = m_mem[a]; rd_known = 1'b1; end
            end
        end
        m_col = exp_col;
        @(posedge clk);
        @(negedge clk);
        check({tag, " col"}, col_ptr, exp_col);
        check({tag, " rvalid"}, rvalid, exp_rv);
        if (exp_rv && rd_known) check({tag, " rdata"}, rdata, exp_rd);
        set_col = 1'b0; req = 1'b0;
    endtask

    task automatic idle(string tag);
        tick(tag, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 col", col_ptr, 0);
        check("R1 rvalid", rvalid, 0);
        check("R1 addr", buf_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // geometry 512 + 16: fill through the boundary (R6, R11)
        pg_sel = 2'd0; spare_size = 8'd16;
        tick("R2 load", 1'b1, 0, 1'b0, 1'b0, 1'b0, 0);
        for (int i = 0; i < 530; i++)
            tick("R6 fill", 1'b0, 0, 1'b0, 1'b1, 1'b1, (i * 7 + 3) & 8'hFF);
        tick("R2 reload", 1'b1, 0, 1'b0, 1'b0, 1'b0, 0);
        for (int i = 0; i < 530; i++)
            tick("R11 readback", 1'b0, 0, 1'b0, 1'b1, 1'b0, 0);

        // explicit boundary crossing R6
        tick("R6 load", 1'b1, 510, 1'b0, 1'b0, 1'b0, 0);
        check("R4 main addr", buf_addr, 510);
        tick("R6 cross", 1'b0, 0, 1'b0, 1'b1, 1'b0, 0);
        tick("R6 cross", 1'b0, 0, 1'b0, 1'b1, 1'b0, 0);
        check("R6 spare0", buf_addr, 13'h1000);
        tick("R6 cross", 1'b0, 0, 1'b0, 1'b1, 1'b0, 0);
        check("R6 spare1", buf_addr, 13'h1001);
        check("R9 rdata", rdata, ((512 * 7 + 3) & 8'hFF));

        // R10 out of range read/write
        tick("R10 load", 1'b1, 528, 1'b0, 1'b0, 1'b0, 0);
        check("R10 addr", buf_addr, 13'h1FFF);
        tick("R10 read", 1'b0, 0, 1'b0, 1'b1, 1'b0, 0);
        check("R10 rdata", rdata, 8'hFF);

        // R3 hold when idle
        idle("R3 idle"); idle("R3 idle");
        check("R3 hold", col_ptr, 529);

        // R2 strobe priority: concurrent write to column 7 dropped
        tick("R2 prio", 1'b1, 7, 1'b0, 1'b1, 1'b1, 8'h00);
        tick("R2 prio read", 1'b0, 0, 1'b0, 1'b1, 1'b0, 0);
        check("R2 unchanged", rdata, (7 * 7 + 3) & 8'hFF);

        // geometry 2048 + 64: share 16 over four windows (R5)
        pg_sel = 2'd2; spare_size = 8'd64;
        tick("R5 load", 1'b1, 2048 + 17, 1'b0, 1'b0, 1'b0, 0);
        check("R5 win1", buf_addr, 13'h1041);
        for (int i = 0; i < 50; i++)
            tick("R5 burst", 1'b0, 0, 1'b0, 1'b1, 1'b1, i + 8'h40);
        tick("R5 reload", 1'b1, 2048 + 17, 1'b0, 1'b0, 1'b0, 0);
        for (int i = 0; i < 50; i++)
            tick("R5 read", 1'b0, 0, 1'b0, 1'b1, 1'b0, 0);

        // R7 spare-only mode
        tick("R7 load", 1'b1, 5, 1'b1, 1'b0, 1'b0, 0);
        check("R7 addr", buf_addr, 13'h1005);
        tick("R7 write", 1'b0, 0, 1'b0, 1'b1, 1'b1, 8'hC3);
        tick("R7 reload", 1'b1, 5, 1'b1, 1'b0, 1'b0, 0);
        tick("R7 read", 1'b0, 0, 1'b0, 1'b1, 1'b0, 0);
        check("R7 rdata", rdata, 8'hC3);

        // R8 uneven share: 70 bytes, share 16, offset 66 folds into window 3
        spare_size = 8'd70;
        tick("R8 load", 1'b1, 66, 1'b1, 1'b0, 1'b0, 0);
        check("R8 fold", buf_addr, 13'h10D2);
        for (int i = 0; i < 6; i++)
            tick("R8 burst", 1'b0, 0, 1'b0, 1'b1, 1'b1, 8'hA0 + i);
        tick("R8 reload", 1'b1, 66, 1'b1, 1'b0, 1'b0, 0);
        for (int i = 0; i < 6; i++)
            tick("R8 read", 1'b0, 0, 1'b0, 1'b1, 1'b0, 0);
        tick("R10 past end", 1'b1, 70, 1'b1, 1'b0, 1'b0, 0);
        check("R10 end addr", buf_addr, 13'h1FFF);

        // R10 window offset beyond 64 bytes: 512 page, 100 spare bytes
        pg_sel = 2'd0; spare_size = 8'd100;
        tick("R10 wide", 1'b1, 512 + 63, 1'b0, 1'b0, 1'b0, 0);
        check("R10 last in window", buf_addr, 13'h103F);
        tick("R10 wide", 1'b0, 0, 1'b0, 1'b1, 1'b1, 8'h11);
        check("R10 wide oob", buf_addr, 13'h1FFF);
        tick("R10 wide write", 1'b0, 0, 1'b0, 1'b1, 1'b1, 8'h22);

        // geometry 1024 + 32 mixed burst across the boundary
        pg_sel = 2'd1; spare_size = 8'd32;
        tick("R6 load2", 1'b1, 1020, 1'b0, 1'b0, 1'b0, 0);
        for (int i = 0; i < 40; i++)
            tick("R6 burst2", 1'b0, 0, 1'b0, 1'b1, 1'b1, 8'h80 ^ i);
        tick("R6 reload2", 1'b1, 1020, 1'b0, 1'b0, 1'b0, 0);
        for (int i = 0; i < 40; i++)
            tick("R11 read2", 1'b0, 0, 1'b0, 1'b1, 1'b0, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule